// File: doc/BRIEF.md
# SPI Command Frame Monitor

This block watches a four-wire SPI link between a host and a network controller whose control registers are split into four banks. It drives nothing on the bus. It brings chip-select, serial clock and both data lines into the system clock domain and builds mode-0 bytes, most significant bit first. When a chip-select frame closes, it issues a one-cycle report. The report gives the command class, the register address, the bank that was in force, the data byte of interest, the last byte the host sent, the byte count and a set of protocol error flags.

The monitor keeps its own copy of the two bank-select bits, because the controller's register map depends on them. Register writes, bit-set and bit-clear commands aimed at the bank-control register update this copy, and so does the reset command. Each bit is unknown until a command first defines it. A side input tells the monitor whether the register being addressed is in the slow MAC/MII class, whose reads need a dummy byte. The system clock must run at least four times as fast as the serial clock.

Top module: `spi_cmd_monitor`

## Requirements
- R1: A frame opens on a falling chip-select and closes on the next rise. `rpt_valid` pulses for exactly one clock, three system clock edges after the raw rise. A frame that held no complete byte gives no report, and a rise with no open frame is ignored.
- R2: Bytes are sampled on rising serial-clock edges, most significant bit first. Bits left over after the last whole byte are discarded.
- R3: `rpt_op` is bits 7:5 of the first byte and `rpt_addr` is bits 4:0. The codes are 0 register read, 1 buffer read, 2 register write, 3 buffer write, 4 bit set, 5 bit clear and 7 reset. Code 6 sets error bit 0 (unknown command) and no other error bit.
- R4: Register write, bit set and bit clear must be exactly 2 bytes, reset exactly 1, and register read 2 or 3. Any other length sets error bit 1 and leaves the bank copy unchanged.
- R5: A buffer read first byte must be exactly 0x3A and a buffer write first byte exactly 0x7A. Any other value with those codes sets error bit 2.
- R6: A register write to address 0x1F loads the bank copy from bits 1:0 of the second byte and marks both bits known.
- R7: Bit set or bit clear at address 0x1F sets or clears each bank bit whose mask bit (second byte, bits 1:0) is 1, and marks those bits known. Other bank bits are left as they were.
- R8: A valid reset command forces the bank copy to 0 and marks both bits known.
- R9: A register command of valid length that runs while either bank bit is unknown sets error bit 3. `rpt_bank` and `rpt_bank_known` give the state from before the frame's own update.
- R10: `rpt_data` depends on the command:
  - register read: the third MISO byte if the frame has exactly 3 bytes, otherwise the second;
  - buffer read: the second MISO byte;
  - register write, buffer write, bit set, bit clear: the second MOSI byte;
  - reset and code 6: zero.
  A byte the frame did not contain counts as zero.
- R11: A register read of valid length with the bank known sets error bit 4 when it has 2 bytes but `mac_class` is 1, or 3 bytes but `mac_class` is 0.
- R12: `rpt_count` is the number of whole bytes, saturating at 255. `rpt_last` is the final whole MOSI byte.
- R13: After reset no report is pending, the report fields are zero, and both bank bits are unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Bus chip-select, active low |
| spi_sck | input | 1 | Bus serial clock |
| spi_mosi | input | 1 | Host-to-device data |
| spi_miso | input | 1 | Device-to-host data |
| mac_class | input | 1 | Addressed register is MAC/MII class; sampled when the frame closes |
| rpt_valid | output | 1 | One-cycle report strobe |
| rpt_op | output | 3 | Command code |
| rpt_addr | output | 5 | Register address field |
| rpt_bank | output | 2 | Bank copy before this frame |
| rpt_bank_known | output | 1 | Both bank bits known before this frame |
| rpt_data | output | 8 | Data byte selected by command |
| rpt_last | output | 8 | Last whole MOSI byte |
| rpt_count | output | 8 | Whole-byte count, saturating |
| rpt_err | output | 5 | Error flags (bit 0 unknown command, 1 length, 2 header, 3 bank unknown, 4 dummy byte) |

## Verification
The report arrives three system clock edges after the raw chip-select rise. Two edges go to the synchronizer and one to the report register. Bank state changes appear only in the report of the next frame. The driver task computes the expected report when it sends a frame and queues it. The monitor compares reports on the falling clock edge, whenever the strobe is high. Six cycles after each rise, the driver checks that the queue has drained, so a late, missing or extra report is counted as an error. Frames with no whole byte queue nothing, and a report that arrives for one is flagged.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

   localparam int BYTE_W = 8;
   localparam int OP_W   = 3;
   localparam int ADR_W  = 5;
   localparam int BANK_W = 2;
   localparam int ERR_W  = 5;

   typedef enum logic [OP_W-1:0] {
      OP_RD_REG  = 3'd0,
      OP_RD_BUF  = 3'd1,
      OP_WR_REG  = 3'd2,
      OP_WR_BUF  = 3'd3,
      OP_BIT_SET = 3'd4,
      OP_BIT_CLR = 3'd5,
      OP_RSVD    = 3'd6,
      OP_RESET   = 3'd7
   } mon_op_e;

   localparam int ERR_UNK_OP   = 0;
   localparam int ERR_LENGTH   = 1;
   localparam int ERR_HEADER   = 2;
   localparam int ERR_BANK_UNK = 3;
   localparam int ERR_DUMMY    = 4;

   localparam logic [BYTE_W-1:0] RD_BUF_HDR = 8'h3A;
   localparam logic [BYTE_W-1:0] WR_BUF_HDR = 8'h7A;

endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_raw,
   input  logic sck_raw,
   input  logic mosi_raw,
   input  logic miso_raw,
   output logic cs_low,
   output logic mosi_s,
   output logic miso_s,
   output logic cs_fall,
   output logic cs_rise,
   output logic sck_rise
);
   localparam int         LANES   = 4;
   localparam logic [3:0] IDLE_VAL = 4'b1000;

   logic [LANES-1:0] chain [STAGES];
   logic             cs_d, sck_d;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= IDLE_VAL;
               else        chain[g] <= {cs_n_raw, sck_raw, mosi_raw, miso_raw};
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= IDLE_VAL;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         cs_d  <= chain[STAGES-1][3];
         sck_d <= chain[STAGES-1][2];
      end
   end

   assign cs_low   = ~chain[STAGES-1][3];
   assign mosi_s   = chain[STAGES-1][1];
   assign miso_s   = chain[STAGES-1][0];
   assign cs_fall  = cs_d & ~chain[STAGES-1][3];
   assign cs_rise  = ~cs_d & chain[STAGES-1][3];
   assign sck_rise = ~sck_d & chain[STAGES-1][2];

endmodule

// File: rtl/spi_mon_shifter.sv
module spi_mon_shifter
   import spi_mon_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_fall,
   input  logic              cs_rise,
   input  logic              cs_low,
   input  logic              sck_rise,
   input  logic              mosi_s,
   input  logic              miso_s,
   output logic [BYTE_W-1:0] hdr,
   output logic [BYTE_W-1:0] b1_mosi,
   output logic [BYTE_W-1:0] b1_miso,
   output logic [BYTE_W-1:0] b2_miso,
   output logic [BYTE_W-1:0] last_mosi,
   output logic [CNT_W-1:0]  byte_cnt,
   output logic              frame_done
);
   localparam int              BIT_W   = $clog2(BYTE_W);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   logic              active;
   logic [BIT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] sh_mosi, sh_miso;
   logic [BYTE_W-1:0] nx_mosi, nx_miso;
   logic              byte_end;

   assign nx_mosi  = {sh_mosi[BYTE_W-2:0], mosi_s};
   assign nx_miso  = {sh_miso[BYTE_W-2:0], miso_s};
   assign byte_end = active & cs_low & sck_rise & (bit_cnt == BIT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         bit_cnt   <= '0;
         sh_mosi   <= '0;
         sh_miso   <= '0;
         hdr       <= '0;
         b1_mosi   <= '0;
         b1_miso   <= '0;
         b2_miso   <= '0;
         last_mosi <= '0;
         byte_cnt  <= '0;
      end else if (cs_fall) begin
         active    <= 1'b1;
         bit_cnt   <= '0;
         hdr       <= '0;
         b1_mosi   <= '0;
         b1_miso   <= '0;
         b2_miso   <= '0;
         last_mosi <= '0;
         byte_cnt  <= '0;
      end else if (cs_rise) begin
         active <= 1'b0;
      end else if (active && cs_low && sck_rise) begin
         sh_mosi <= nx_mosi;
         sh_miso <= nx_miso;
         bit_cnt <= bit_cnt + 1'b1;
         if (byte_end) begin
            last_mosi <= nx_mosi;
            if (byte_cnt == CNT_W'(0)) hdr <= nx_mosi;
            if (byte_cnt == CNT_W'(1)) begin
               b1_mosi <= nx_mosi;
               b1_miso <= nx_miso;
            end
            if (byte_cnt == CNT_W'(2)) b2_miso <= nx_miso;
            if (byte_cnt != CNT_MAX)   byte_cnt <= byte_cnt + 1'b1;
         end
      end
   end

   assign frame_done = cs_rise & active & (byte_cnt != '0);

endmodule

// File: rtl/spi_mon_decoder.sv
module spi_mon_decoder
   import spi_mon_pkg::*;
#(
   parameter int               CNT_W    = 8,
   parameter logic [ADR_W-1:0] BANK_REG = 5'h1F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_done,
   input  logic [BYTE_W-1:0] hdr,
   input  logic [BYTE_W-1:0] b1_mosi,
   input  logic [BYTE_W-1:0] b1_miso,
   input  logic [BYTE_W-1:0] b2_miso,
   input  logic [BYTE_W-1:0] last_mosi,
   input  logic [CNT_W-1:0]  byte_cnt,
   input  logic              mac_class,
   output logic              rpt_valid,
   output logic [OP_W-1:0]   rpt_op,
   output logic [ADR_W-1:0]  rpt_addr,
   output logic [BANK_W-1:0] rpt_bank,
   output logic              rpt_bank_known,
   output logic [BYTE_W-1:0] rpt_data,
   output logic [BYTE_W-1:0] rpt_last,
   output logic [CNT_W-1:0]  rpt_count,
   output logic [ERR_W-1:0]  rpt_err,
   output logic [BANK_W-1:0] shadow_bank,
   output logic [BANK_W-1:0] shadow_known
);
   mon_op_e           op;
   logic [ADR_W-1:0]  addr;
   logic              on_bank_reg, all_known;
   logic              is_regop, len_chk, len_ok;
   logic [ERR_W-1:0]  err_c;
   logic [BYTE_W-1:0] data_c;
   logic [BANK_W-1:0] mask, bank_nx, known_nx;

   assign op          = mon_op_e'(hdr[BYTE_W-1 -: OP_W]);
   assign addr        = hdr[ADR_W-1:0];
   assign on_bank_reg = (addr == BANK_REG);
   assign all_known   = &shadow_known;
   assign mask        = b1_mosi[BANK_W-1:0];
   assign is_regop    = (op == OP_RD_REG) || (op == OP_WR_REG) ||
                        (op == OP_BIT_SET) || (op == OP_BIT_CLR);

   always_comb begin
      len_chk = 1'b1;
      len_ok  = 1'b1;
      unique case (op)
         OP_RD_REG:  len_ok = (byte_cnt == CNT_W'(2)) || (byte_cnt == CNT_W'(3));
         OP_WR_REG,
         OP_BIT_SET,
         OP_BIT_CLR: len_ok = (byte_cnt == CNT_W'(2));
         OP_RESET:   len_ok = (byte_cnt == CNT_W'(1));
         default:    len_chk = 1'b0;
      endcase
   end

   always_comb begin
      err_c               = '0;
      err_c[ERR_UNK_OP]   = (op == OP_RSVD);
      err_c[ERR_LENGTH]   = len_chk & ~len_ok;
      err_c[ERR_HEADER]   = ((op == OP_RD_BUF) && (hdr != RD_BUF_HDR)) ||
                            ((op == OP_WR_BUF) && (hdr != WR_BUF_HDR));
      err_c[ERR_BANK_UNK] = is_regop & len_ok & ~all_known;
      err_c[ERR_DUMMY]    = (op == OP_RD_REG) & len_ok & all_known &
                            (mac_class ? (byte_cnt != CNT_W'(3))
                                       : (byte_cnt != CNT_W'(2)));
   end

   always_comb begin
      unique case (op)
         OP_RD_REG:  data_c = (byte_cnt == CNT_W'(3)) ? b2_miso : b1_miso;
         OP_RD_BUF:  data_c = b1_miso;
         OP_WR_REG,
         OP_WR_BUF,
         OP_BIT_SET,
         OP_BIT_CLR: data_c = b1_mosi;
         default:    data_c = '0;
      endcase
   end

   always_comb begin
      bank_nx  = shadow_bank;
      known_nx = shadow_known;
      if (len_ok) begin
         unique case (op)
            OP_WR_REG: if (on_bank_reg) begin
               bank_nx  = mask;
               known_nx = '1;
            end
            OP_BIT_SET: if (on_bank_reg) begin
               bank_nx  = shadow_bank | mask;
               known_nx = shadow_known | mask;
            end
            OP_BIT_CLR: if (on_bank_reg) begin
               bank_nx  = shadow_bank & ~mask;
               known_nx = shadow_known | mask;
            end
            OP_RESET: begin
               bank_nx  = '0;
               known_nx = '1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rpt_valid      <= 1'b0;
         rpt_op         <= '0;
         rpt_addr       <= '0;
         rpt_bank       <= '0;
         rpt_bank_known <= 1'b0;
         rpt_data       <= '0;
         rpt_last       <= '0;
         rpt_count      <= '0;
         rpt_err        <= '0;
         shadow_bank    <= '0;
         shadow_known   <= '0;
      end else begin
         rpt_valid <= frame_done;
         if (frame_done) begin
            rpt_op         <= op;
            rpt_addr       <= addr;
            rpt_bank       <= shadow_bank;
            rpt_bank_known <= all_known;
            rpt_data       <= data_c;
            rpt_last       <= last_mosi;
            rpt_count      <= byte_cnt;
            rpt_err        <= err_c;
            shadow_bank    <= bank_nx;
            shadow_known   <= known_nx;
         end
      end
   end

endmodule

// File: rtl/spi_cmd_monitor.sv
module spi_cmd_monitor
   import spi_mon_pkg::*;
#(
   parameter int               SYNC_STAGES = 2,
   parameter int               CNT_W       = 8,
   parameter logic [ADR_W-1:0] BANK_REG    = 5'h1F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   input  logic              spi_miso,
   input  logic              mac_class,
   output logic              rpt_valid,
   output logic [2:0]        rpt_op,
   output logic [4:0]        rpt_addr,
   output logic [1:0]        rpt_bank,
   output logic              rpt_bank_known,
   output logic [7:0]        rpt_data,
   output logic [7:0]        rpt_last,
   output logic [CNT_W-1:0]  rpt_count,
   output logic [4:0]        rpt_err
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must hold a count of 3");
      end
   endgenerate

   logic              cs_low_w, mosi_w, miso_w;
   logic              cs_fall_w, cs_rise_w, sck_rise_w;
   logic [BYTE_W-1:0] hdr_w, b1_mosi_w, b1_miso_w, b2_miso_w, last_w;
   logic [CNT_W-1:0]  cnt_w;
   logic              done_w;
   logic [BANK_W-1:0] shadow_bank_w, shadow_known_w;

   spi_mon_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n_raw (spi_cs_n),
      .sck_raw  (spi_sck),
      .mosi_raw (spi_mosi),
      .miso_raw (spi_miso),
      .cs_low   (cs_low_w),
      .mosi_s   (mosi_w),
      .miso_s   (miso_w),
      .cs_fall  (cs_fall_w),
      .cs_rise  (cs_rise_w),
      .sck_rise (sck_rise_w)
   );

   spi_mon_shifter #(.CNT_W(CNT_W)) shift_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_fall    (cs_fall_w),
      .cs_rise    (cs_rise_w),
      .cs_low     (cs_low_w),
      .sck_rise   (sck_rise_w),
      .mosi_s     (mosi_w),
      .miso_s     (miso_w),
      .hdr        (hdr_w),
      .b1_mosi    (b1_mosi_w),
      .b1_miso    (b1_miso_w),
      .b2_miso    (b2_miso_w),
      .last_mosi  (last_w),
      .byte_cnt   (cnt_w),
      .frame_done (done_w)
   );

   spi_mon_decoder #(.CNT_W(CNT_W), .BANK_REG(BANK_REG)) dec_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .frame_done     (done_w),
      .hdr            (hdr_w),
      .b1_mosi        (b1_mosi_w),
      .b1_miso        (b1_miso_w),
      .b2_miso        (b2_miso_w),
      .last_mosi      (last_w),
      .byte_cnt       (cnt_w),
      .mac_class      (mac_class),
      .rpt_valid      (rpt_valid),
      .rpt_op         (rpt_op),
      .rpt_addr       (rpt_addr),
      .rpt_bank       (rpt_bank),
      .rpt_bank_known (rpt_bank_known),
      .rpt_data       (rpt_data),
      .rpt_last       (rpt_last),
      .rpt_count      (rpt_count),
      .rpt_err        (rpt_err),
      .shadow_bank    (shadow_bank_w),
      .shadow_known   (shadow_known_w)
   );

endmodule

// File: rtl/spi_cmd_monitor_chk.sv
module spi_cmd_monitor_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_rise,
   input logic             rpt_valid,
   input logic [2:0]       rpt_op,
   input logic             rpt_bank_known,
   input logic [CNT_W-1:0] rpt_count,
   input logic [4:0]       rpt_err,
   input logic [1:0]       shadow_bank,
   input logic [1:0]       shadow_known
);
   // R1
   report_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid |=> !rpt_valid);

   // R1
   report_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid |-> $past(cs_rise));

   // R12
   report_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid |-> (rpt_count != '0));

   // R3
   unknown_op_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid && rpt_op == 3'd6) |-> (rpt_err == 5'b00001));

   // R4
   two_byte_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid && (rpt_op == 3'd2 || rpt_op == 3'd4 || rpt_op == 3'd5))
         |-> (rpt_err[1] == (rpt_count != CNT_W'(2))));

   // R8
   reset_cmd_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid && rpt_op == 3'd7 && !rpt_err[1])
         |-> (shadow_bank == 2'b00 && shadow_known == 2'b11));

   // R9
   bank_unk_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid && rpt_err[3]) |-> !rpt_bank_known);

endmodule

bind spi_cmd_monitor spi_cmd_monitor_chk #(.CNT_W(CNT_W)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .cs_rise        (cs_rise_w),
   .rpt_valid      (rpt_valid),
   .rpt_op         (rpt_op),
   .rpt_bank_known (rpt_bank_known),
   .rpt_count      (rpt_count),
   .rpt_err        (rpt_err),
   .shadow_bank    (shadow_bank_w),
   .shadow_known   (shadow_known_w)
);

// File: tb/spi_cmd_monitor_tb_top.sv
module spi_cmd_monitor_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, miso = 1'b0, mac = 1'b0;
   logic       rpt_valid, rpt_bank_known;
   logic [2:0] rpt_op;
   logic [4:0] rpt_addr, rpt_err;
   logic [1:0] rpt_bank;
   logic [7:0] rpt_data, rpt_last, rpt_count;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [39:0] exp_q[$];
   string       tag_q[$];

   logic [7:0] tx_m [0:299];
   logic [7:0] tx_s [0:299];
   logic [1:0] m_bank = 2'b00;
   logic [1:0] m_known = 2'b00;

   always #2 clk = ~clk;

   spi_cmd_monitor dut_i (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
      .spi_mosi(mosi), .spi_miso(miso), .mac_class(mac),
      .rpt_valid(rpt_valid), .rpt_op(rpt_op), .rpt_addr(rpt_addr),
      .rpt_bank(rpt_bank), .rpt_bank_known(rpt_bank_known),
      .rpt_data(rpt_data), .rpt_last(rpt_last), .rpt_count(rpt_count),
      .rpt_err(rpt_err)
   );

   // Reference model built from the requirements; pushes one expected report.
   task automatic model_frame(input int n, input bit is_mac, input string tag);
      logic [2:0] op;
      logic [4:0] ad;
      logic [7:0] data, last, cnt, b1m, b1s, b2s;
      logic [4:0] err;
      bit len_ok, len_chk, regop, kn;
      logic [1:0] mk;
      op  = tx_m[0][7:5];
      ad  = tx_m[0][4:0];
      b1m = (n > 1) ? tx_m[1] : 8'h00;
      b1s = (n > 1) ? tx_s[1] : 8'h00;
      b2s = (n > 2) ? tx_s[2] : 8'h00;
      last = tx_m[n-1];
      cnt = (n > 255) ? 8'd255 : 8'(n);
      kn  = (m_known == 2'b11);
      len_chk = 1; len_ok = 1;
      case (op)
         3'd0: len_ok = (n == 2 || n == 3);
         3'd2, 3'd4, 3'd5: len_ok = (n == 2);
         3'd7: len_ok = (n == 1);
         default: len_chk = 0;
      endcase
      regop = (op == 0 || op == 2 || op == 4 || op == 5);
      err = '0;
      err[0] = (op == 6);
      err[1] = len_chk && !len_ok;
      err[2] = (op == 1 && tx_m[0] != 8'h3A) || (op == 3 && tx_m[0] != 8'h7A);
      err[3] = regop && len_ok && !kn;
      err[4] = (op == 0) && len_ok && kn && (is_mac ? (n != 3) : (n != 2));
      case (op)
         3'd0: data = (n == 3) ? b2s : b1s;
         3'd1: data = b1s;
         3'd2, 3'd3, 3'd4, 3'd5: data = b1m;
         default: data = 8'h00;
      endcase
      exp_q.push_back({op, ad, m_bank, kn, data, last, cnt, err});
      tag_q.push_back(tag);
      mk = b1m[1:0];
      if (len_ok) begin
         if (op == 2 && ad == 5'h1F) begin m_bank = mk; m_known = 2'b11; end
         if (op == 4 && ad == 5'h1F) begin m_bank |= mk; m_known |= mk; end
         if (op == 5 && ad == 5'h1F) begin m_bank &= ~mk; m_known |= mk; end
         if (op == 7) begin m_bank = 2'b00; m_known = 2'b11; end
      end
   endtask

   task automatic send_bits(input logic [7:0] bm, input logic [7:0] bs, input int nb);
      for (int b = 7; b > 7 - nb; b--) begin
         @(negedge clk); mosi = bm[b]; miso = bs[b];
         repeat (4) @(negedge clk); sck = 1'b1;
         repeat (4) @(negedge clk); sck = 1'b0;
      end
   endtask

   // Drives one frame of n whole bytes plus extra trailing bits.
   task automatic send_frame(input int n, input int extra, input bit is_mac, input string tag);
      if (n > 0) model_frame(n, is_mac, tag);
      @(negedge clk); mac = is_mac; cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < n; i++) send_bits(tx_m[i], tx_s[i], 8);
      if (extra > 0) send_bits(8'hFF, 8'hFF, extra);
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R1 %s: report not seen within 6 cycles, pending=%0d expected=0",
                  tag, exp_q.size());
         exp_q.delete(); tag_q.delete();
      end
      repeat (6) @(negedge clk);
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rpt_valid) begin
         logic [39:0] act;
         act = {rpt_op, rpt_addr, rpt_bank, rpt_bank_known, rpt_data, rpt_last,
                rpt_count, rpt_err};
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R1 unexpected report actual=%h expected=none", act);
         end else begin
            logic [39:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (act !== e) begin
               errors++;
               $display("FAIL %s actual=%h expected=%h", t, act, e);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      // R13: reset state
      checks++;
      if (rpt_valid !== 1'b0 || rpt_count !== 8'd0 || rpt_bank_known !== 1'b0 ||
          rpt_err !== 5'd0) begin
         errors++;
         $display("FAIL R13 reset state actual=%b/%0d/%b expected=0/0/0",
                  rpt_valid, rpt_count, rpt_bank_known);
      end
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R9 R10: read while bank unknown
      tx_m[0] = 8'h05; tx_m[1] = 8'h00; tx_s[0] = 8'h00; tx_s[1] = 8'hA5;
      send_frame(2, 0, 0, "R9 R10 read with bank unknown");
      // R7: bit set makes bit 0 known only
      tx_m[0] = 8'h9F; tx_m[1] = 8'h01; tx_s[1] = 8'h33;
      send_frame(2, 0, 0, "R7 bit set while unknown");
      tx_m[0] = 8'h06; tx_m[1] = 8'h00; tx_s[1] = 8'h3C;
      send_frame(2, 0, 0, "R9 still partly unknown");
      // R6: write bank register
      tx_m[0] = 8'h5F; tx_m[1] = 8'h02;
      send_frame(2, 0, 0, "R6 write bank reg");
      // R11 R10: mac read with dummy byte
      tx_m[0] = 8'h1A; tx_m[1] = 8'h00; tx_m[2] = 8'h00;
      tx_s[1] = 8'hEE; tx_s[2] = 8'h42;
      send_frame(3, 0, 1, "R10 R11 mac read 3 bytes");
      send_frame(2, 0, 1, "R11 mac read missing dummy");
      send_frame(3, 0, 0, "R11 plain read with dummy");
      // R4: read too long
      tx_m[3] = 8'h99; tx_s[3] = 8'h77;
      send_frame(4, 0, 0, "R4 read length 4");
      // R7: set and clear
      tx_m[0] = 8'h9F; tx_m[1] = 8'h01;
      send_frame(2, 0, 0, "R7 bit set bank reg");
      tx_m[0] = 8'hBF; tx_m[1] = 8'h02;
      send_frame(2, 0, 0, "R7 bit clear bank reg");
      // R4: write too long, no update
      tx_m[0] = 8'h5F; tx_m[1] = 8'h03; tx_m[2] = 8'h00;
      send_frame(3, 0, 0, "R4 write length 3");
      // R8: reset
      tx_m[0] = 8'hFF;
      send_frame(1, 0, 0, "R8 reset command");
      tx_m[0] = 8'hFF; tx_m[1] = 8'h00;
      send_frame(2, 0, 0, "R4 reset length 2");
      // R3: reserved code
      tx_m[0] = 8'hC3; tx_m[1] = 8'h12;
      send_frame(2, 0, 0, "R3 unknown opcode");
      // R5: buffer headers
      tx_m[0] = 8'h3A; tx_m[1] = 8'h00; tx_m[2] = 8'h00; tx_m[3] = 8'h00;
      tx_s[1] = 8'h11; tx_s[2] = 8'h22; tx_s[3] = 8'h33;
      send_frame(4, 0, 0, "R5 R10 buffer read");
      tx_m[0] = 8'h3B;
      send_frame(2, 0, 0, "R5 bad buffer read header");
      tx_m[0] = 8'h7A; tx_m[1] = 8'hC8; tx_m[2] = 8'h19;
      send_frame(3, 3, 0, "R2 R5 buffer write with trailing bits");
      tx_m[0] = 8'h60;
      send_frame(2, 0, 0, "R5 bad buffer write header");
      // R1: empty and partial-only frames give no report
      send_frame(0, 0, 0, "R1 empty frame");
      send_frame(0, 5, 0, "R1 partial byte frame");
      // R12: saturation
      tx_m[0] = 8'h7A;
      for (int i = 1; i < 300; i++) tx_m[i] = 8'(i * 3);
      send_frame(300, 0, 0, "R12 long frame saturates");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule